// File: doc/BRIEF.md
# Address-Window Trace Access Filter

This block sits beside a bus observation point and decides, access by access, whether a data-trace message should be emitted. It holds a small bank of programmable address windows. Each window has an inclusive lower and upper bound, a sense bit that selects accesses either inside or outside the bounds, a side select (instruction fetch side or data side), and a direction qualifier. Software programs the windows through a simple single-cycle register write port.

Each observed access arrives with a valid strobe, a 32-bit address, a side flag and a direction flag. One clock later the block reports the decision: pass or drop, together with the index of the lowest-numbered window that accepted the access. A global trace-enable input gates the whole decision. Message formatting, the trace port and start/stop sequencing are left to neighbouring logic.

Top module: `trace_window_filter`

## Requirements
- R1: The block holds NUM_WIN windows (default 4, a build value of 2 is also accepted). A configuration write addresses window `cfgAddr[CFG_AW-1:2]`, register `cfgAddr[1:0]`: 0 = lower bound, 1 = upper bound, 2 = mode, 3 = enable (bit 0). A write changes only the addressed register of the addressed window.
- R2: Bounds are inclusive at both ends and compared as unsigned 32-bit values.
- R3: Mode bit 0 set makes a window accept addresses outside its bounds instead of inside.
- R4: Mode bit 1 selects the side: 1 = instruction side, 0 = data side. An access matches only a window of its own side. After reset every window is data side.
- R5: Mode bits 3:2 qualify direction: 1 = reads only, 2 = writes only, 0 or 3 = either direction.
- R6: An access passes when at least one enabled window accepts it. A disabled window never accepts; with no window enabled every access is dropped.
- R7: The decision is registered: `outValid`, `outPass` and `outWin` reflect the access presented at the previous rising edge. `outValid` is low and `outPass` is low after a cycle with `accValid` low.
- R8: When an access passes, `outWin` is the lowest index among the accepting windows; it is 0 when the access is dropped.
- R9: With `traceEn` low when the access is presented, the decision is drop regardless of windows.
- R10: Reset clears the outputs to zero and disables every window.
- R11: A configuration write and an access in the same cycle: the access is judged on the settings held before that write; the new setting applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| traceEn | input | 1 | Global trace enable; low forces drop |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW | Window index (upper bits) and register select (bits 1:0) |
| cfgData | input | ADDR_W | Configuration write data |
| accValid | input | 1 | Observed access present this cycle |
| accAddr | input | ADDR_W | Access address |
| accInstr | input | 1 | 1 = instruction-side access, 0 = data-side |
| accWrite | input | 1 | 1 = write, 0 = read |
| outValid | output | 1 | A decision is present |
| outPass | output | 1 | 1 = emit a trace message, 0 = drop |
| outWin | output | IDX_W | Lowest accepting window index |

## Verification
The two functions that can meet in one cycle are a configuration write and the judging of an access against the same window. The bench provokes this by presenting an access inside window 0 while, in the very same cycle, writing 0 to that window's enable register. It judges the outcome by expecting the access to pass on window 0 under the old setting and a repeat of the identical access one cycle later to be dropped.

// File: rtl/trcflt_pkg.sv
package trcflt_pkg;

  localparam int MAX_WIN = 4;

  typedef enum logic [1:0] {
    DIR_EITHER = 2'd0,
    DIR_READ   = 2'd1,
    DIR_WRITE  = 2'd2,
    DIR_BOTH   = 2'd3
  } dirSel_t;

  // bit 0 outside, bit 1 instruction side, bits 3:2 direction
  typedef struct packed {
    dirSel_t dir;
    logic    instrSide;
    logic    outside;
  } winMode_t;

  typedef struct packed {
    logic [MAX_WIN-1:0] baseWe;
    logic [MAX_WIN-1:0] limitWe;
    logic [MAX_WIN-1:0] modeWe;
    logic [MAX_WIN-1:0] enWe;
    logic               gateOpen;
  } fltStrobe_t;

endpackage

// File: rtl/trcflt_window.sv
module trcflt_window
  import trcflt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWe,
  input  logic              limitWe,
  input  logic              modeWe,
  input  logic              enWe,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accInstr,
  input  logic              accWrite,
  output logic              hit
);

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] limitQ;
  winMode_t          modeQ;
  logic              enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      limitQ <= '0;
      modeQ  <= '{dir: DIR_EITHER, instrSide: 1'b0, outside: 1'b0};
      enQ    <= 1'b0;
    end else begin
      if (baseWe)  baseQ  <= wrData;
      if (limitWe) limitQ <= wrData;
      if (modeWe)  modeQ  <= winMode_t'(wrData[3:0]);
      if (enWe)    enQ    <= wrData[0];
    end
  end

  logic inRange;
  logic senseOk;
  logic sideOk;
  logic dirOk;

  always_comb begin
    inRange = (accAddr >= baseQ) && (accAddr <= limitQ);
    senseOk = modeQ.outside ? !inRange : inRange;
    sideOk  = (accInstr == modeQ.instrSide);
    unique case (modeQ.dir)
      DIR_READ:  dirOk = !accWrite;
      DIR_WRITE: dirOk = accWrite;
      default:   dirOk = 1'b1;
    endcase
    hit = enQ && senseOk && sideOk && dirOk;
  end

endmodule

// File: rtl/trcflt_ctrl.sv
module trcflt_ctrl
  import trcflt_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int CFG_AW = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceEn,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              accValid,
  output fltStrobe_t        strb,
  output logic              outValid
);

  logic [IDX_W-1:0] winSel;
  logic [1:0]       regSel;

  assign winSel = cfgAddr[CFG_AW-1:2];
  assign regSel = cfgAddr[1:0];

  for (genvar w = 0; w < MAX_WIN; w++) begin : gDec
    if (w < NUM_WIN) begin : gLive
      logic selMe;
      assign selMe            = cfgWe && (winSel == IDX_W'(w));
      assign strb.baseWe[w]  = selMe && (regSel == 2'd0);
      assign strb.limitWe[w] = selMe && (regSel == 2'd1);
      assign strb.modeWe[w]  = selMe && (regSel == 2'd2);
      assign strb.enWe[w]    = selMe && (regSel == 2'd3);
    end else begin : gIdle
      assign strb.baseWe[w]  = 1'b0;
      assign strb.limitWe[w] = 1'b0;
      assign strb.modeWe[w]  = 1'b0;
      assign strb.enWe[w]    = 1'b0;
    end
  end

  assign strb.gateOpen = accValid && traceEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= accValid;
  end

  AST_ONE_CFG_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.baseWe, strb.limitWe, strb.modeWe, strb.enWe}) <= 1); // R1

  AST_CFG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |-> ({strb.baseWe, strb.limitWe, strb.modeWe, strb.enWe} == '0)); // R1

endmodule

// File: rtl/trcflt_datapath.sv
module trcflt_datapath
  import trcflt_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fltStrobe_t        strb,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accInstr,
  input  logic              accWrite,
  output logic              outPass,
  output logic [IDX_W-1:0]  outWin
);

  logic [NUM_WIN-1:0] hitVec;

  for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
    trcflt_window #(.ADDR_W(ADDR_W)) uWin (
      .clk      (clk),
      .rstN     (rstN),
      .baseWe   (strb.baseWe[w]),
      .limitWe  (strb.limitWe[w]),
      .modeWe   (strb.modeWe[w]),
      .enWe     (strb.enWe[w]),
      .wrData   (cfgData),
      .accAddr  (accAddr),
      .accInstr (accInstr),
      .accWrite (accWrite),
      .hit      (hitVec[w])
    );
  end

  logic             anyHit;
  logic [IDX_W-1:0] firstHit;

  always_comb begin
    anyHit   = |hitVec;
    firstHit = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hitVec[i]) firstHit = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outPass <= 1'b0;
      outWin  <= '0;
    end else begin
      outPass <= strb.gateOpen && anyHit;
      outWin  <= (strb.gateOpen && anyHit) ? firstHit : '0;
    end
  end

  AST_NO_HIT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hitVec) == '0) |-> !outPass); // R6

  AST_LOWEST_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    outPass |-> ((($past(hitVec) >> outWin) & NUM_WIN'(1)) != '0)
             && (($past(hitVec) & ((NUM_WIN'(1) << outWin) - NUM_WIN'(1))) == '0)); // R8

  AST_DROP_WIN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !outPass |-> (outWin == '0)); // R8

endmodule

// File: rtl/trace_window_filter.sv
module trace_window_filter
  import trcflt_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int CFG_AW = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceEn,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accInstr,
  input  logic              accWrite,
  output logic              outValid,
  output logic              outPass,
  output logic [IDX_W-1:0]  outWin
);

  if (NUM_WIN != 2 && NUM_WIN != MAX_WIN) begin : gBadCount
    $error("trace_window_filter: NUM_WIN must be 2 or 4");
  end

  fltStrobe_t strb;

  trcflt_ctrl #(.NUM_WIN(NUM_WIN)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .traceEn  (traceEn),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .accValid (accValid),
    .strb     (strb),
    .outValid (outValid)
  );

  trcflt_datapath #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgData  (cfgData),
    .accAddr  (accAddr),
    .accInstr (accInstr),
    .accWrite (accWrite),
    .outPass  (outPass),
    .outWin   (outWin)
  );

  AST_PASS_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    outPass |-> outValid); // R7

  AST_TRACE_OFF_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(traceEn) |-> !outPass); // R9

  AST_IDLE_NO_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    !$past(accValid) |-> (!outValid && !outPass)); // R7

endmodule

// File: tb/tb_trace_window_filter.sv
module tb_trace_window_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        traceEn = 1'b1;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accInstr = 1'b0;
  logic        accWrite = 1'b0;
  logic        outValid;
  logic        outPass;
  logic [1:0]  outWin;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  trace_window_filter dut (
    .clk(clk), .rstN(rstN), .traceEn(traceEn),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .accValid(accValid), .accAddr(accAddr), .accInstr(accInstr), .accWrite(accWrite),
    .outValid(outValid), .outPass(outPass), .outWin(outWin)
  );

  // {addr, instr, write, traceEn, expPass, expWin, req}
  localparam int NVEC = 15;
  localparam logic [41:0] VEC [NVEC] = '{
    {32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 4'd2}, // R2 lower bound
    {32'h0000_1FFF, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 4'd2}, // R2 upper bound
    {32'h0000_0FFF, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd2}, // R2 one below
    {32'h0000_2000, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 4'd5}, // R5 write-only accepts write
    {32'h0000_2000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd5}, // R5 write-only rejects read
    {32'h0000_1800, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 4'd8}, // R8 overlap picks 0
    {32'h0000_3000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 4'd3}, // R3 inside inverted window
    {32'h0000_2FFF, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 4'd3}, // R3 just outside
    {32'h0000_2FFF, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'd5}, // R5 read-only rejects write
    {32'h0000_1500, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 4'd4}, // R4 data window skips fetch
    {32'h9000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 4'd2}, // R2 unsigned high range
    {32'h9000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 4'd5}, // R5 read-only window 3
    {32'h0000_1500, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd9}, // R9 trace disabled
    {32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 4'd2}, // R2 top of space
    {32'h0000_4000, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 4'd3}  // R3 above inverted window
  };

  function automatic string reqName(input logic [3:0] n);
    case (n)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] win, input logic [1:0] regSel, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = {win, regSel}; cfgData = data;
    @(posedge clk);
    #1 cfgWe = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input logic i, input logic w, input logic te);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accInstr = i; accWrite = w; traceEn = te;
    @(posedge clk);
    #1 accValid = 1'b0; traceEn = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    testCount++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10", "outValid", 32'(outValid), 0);
    chk("R10", "outPass", 32'(outPass), 0);
    chk("R10", "outWin", 32'(outWin), 0);
    @(negedge clk) rstN = 1'b1;

    // R6: nothing enabled after reset -> drop
    access(32'h0000_1000, 1'b0, 1'b0, 1'b1);
    chk("R6", "valid with no window", 32'(outValid), 1);
    chk("R6", "pass with no window", 32'(outPass), 0);

    // R4: default side is data (only bounds and enable written)
    cfgWrite(2'd0, 2'd0, 32'h0000_1000);
    cfgWrite(2'd0, 2'd1, 32'h0000_1FFF);
    cfgWrite(2'd0, 2'd3, 32'h1);
    access(32'h0000_1500, 1'b0, 1'b0, 1'b1);
    chk("R4", "default data access pass", 32'(outPass), 1);
    access(32'h0000_1500, 1'b1, 1'b0, 1'b1);
    chk("R4", "default fetch pass", 32'(outPass), 0);

    // R1: program remaining windows through the address map
    cfgWrite(2'd0, 2'd2, 32'h0);          // inside, data, either
    cfgWrite(2'd1, 2'd0, 32'h0000_1800);
    cfgWrite(2'd1, 2'd1, 32'h0000_27FF);
    cfgWrite(2'd1, 2'd2, 32'h8);          // inside, data, write only
    cfgWrite(2'd1, 2'd3, 32'h1);
    cfgWrite(2'd2, 2'd0, 32'h0000_3000);
    cfgWrite(2'd2, 2'd1, 32'h0000_3FFF);
    cfgWrite(2'd2, 2'd2, 32'h7);          // outside, instruction, read only
    cfgWrite(2'd2, 2'd3, 32'h1);
    cfgWrite(2'd3, 2'd0, 32'h8000_0000);
    cfgWrite(2'd3, 2'd1, 32'hFFFF_FFFF);
    cfgWrite(2'd3, 2'd2, 32'h4);          // inside, data, read only
    cfgWrite(2'd3, 2'd3, 32'h1);

    for (int k = 0; k < NVEC; k++) begin
      access(VEC[k][41:10], VEC[k][9], VEC[k][8], VEC[k][7]);
      chk(reqName(VEC[k][3:0]), $sformatf("vec %0d pass", k), 32'(outPass), 32'(VEC[k][6]));
      chk(reqName(VEC[k][3:0]), $sformatf("vec %0d win", k), 32'(outWin), 32'(VEC[k][5:4]));
    end

    // R7: a cycle without an access produces no decision
    @(posedge clk);
    #1;
    chk("R7", "idle outValid", 32'(outValid), 0);
    chk("R7", "idle outPass", 32'(outPass), 0);

    // R6: disabling window 1 removes its match
    cfgWrite(2'd1, 2'd3, 32'h0);
    access(32'h0000_2000, 1'b0, 1'b1, 1'b1);
    chk("R6", "disabled window pass", 32'(outPass), 0);

    // R11: same-cycle disable of window 0 and access inside it
    @(negedge clk);
    accValid = 1'b1; accAddr = 32'h0000_1500; accInstr = 1'b0; accWrite = 1'b0;
    cfgWe = 1'b1; cfgAddr = {2'd0, 2'd3}; cfgData = 32'h0;
    @(posedge clk);
    #1 accValid = 1'b0; cfgWe = 1'b0;
    chk("R11", "old setting pass", 32'(outPass), 1);
    chk("R11", "old setting win", 32'(outWin), 0);
    access(32'h0000_1500, 1'b0, 1'b0, 1'b1);
    chk("R11", "new setting pass", 32'(outPass), 0);

    finish();
  end

endmodule